// File: doc/BRIEF.md
# Configurable Watchdog Timer

This block counts ticks from one of two clock sources and raises a one-cycle timeout pulse when the count reaches a selected terminal value. The reset logic elsewhere on the chip uses this pulse to restart the system when software has stopped clearing the watchdog. Software keeps the system alive by pulsing the clear strobe more often than the timeout period.

Two static options shape the timer. The source select picks either a free-running low-power oscillator tick, which keeps counting through power-down, or the instruction clock, which is the block clock divided by four inside the block and stops during power-down. The ratio select picks a terminal count of 2^B, 2^(B+1), 2^(B+2) or 2^(B+3) source ticks, where B is the parameter `BASE_LOG2` (13 by default, which gives 2^13 to 2^16). A global disable option turns every watchdog operation into a no-op.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low, `wdt_timeout` is low, and the tick count and prescaler are cleared, so the first period after reset is a full period.
- R2: With `cfg_src_sel` = 0 (oscillator source), `wdt_timeout` goes high in the cycle after the clock edge that counts the N-th `osc_tick` pulse since reset or clear, where N = 2^(BASE_LOG2 + `cfg_ratio`) and `cfg_ratio` 0..3 selects the four ratios in rising order.
- R3: With `cfg_src_sel` = 1 (instruction source), one tick is counted on every fourth clock edge after reset or clear, so `wdt_timeout` is high after the 4N-th clock edge and low after the edges before it.
- R4: `wdt_timeout` is high for exactly one cycle per expiry, and the count restarts from zero so the next expiry needs another N ticks.
- R5: `sw_clear` sets the tick count and the prescaler to zero on the next clock edge and wins over a tick that arrives in the same cycle, which then produces no timeout.
- R6: While `cfg_disable` is high, no timeout is produced, `sw_clear` has no visible effect, and the count and prescaler are held at zero, so a full period is needed after re-enabling.
- R7: With the oscillator source, counting continues while `pwr_down` is high.
- R8: With the instruction source, the count and prescaler hold while `pwr_down` is high and resume from where they stopped when it falls.
- R9: The source that is not selected has no effect: `osc_tick` is ignored with the instruction source, and with the oscillator source clock cycles without `osc_tick` never expire the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the instruction clock is this divided by four |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_disable | input | 1 | Static option: 1 turns the watchdog off entirely |
| cfg_src_sel | input | 1 | Static option: 0 oscillator tick, 1 instruction clock |
| cfg_ratio | input | 2 | Static option: terminal count 2^(BASE_LOG2 + value) |
| osc_tick | input | 1 | Single-cycle tick from the low-power oscillator, synchronous to clk |
| pwr_down | input | 1 | High while the system is in power-down |
| sw_clear | input | 1 | Software clear strobe, one cycle |
| wdt_timeout | output | 1 | One-cycle pulse on expiry, used as a reset request |

## Verification
The bench builds the block with `BASE_LOG2` = 4, so the four ratios become 16, 32, 64 and 128 ticks and the longest instruction-clock period is 512 cycles. That makes every ratio, back-to-back expiries, the exact cycle of expiry on both sources and the power-down hold and resume all reachable within a short directed run. The count width and terminal compares are the same structure as at the default, only narrower.

// File: rtl/wdog_pkg.sv
// Package: shared types for the watchdog timer.
// Assumes cfg_src_sel is a single static bit; enum gives its two codes names.
package wdog_pkg;

    typedef enum logic {
        SRC_OSC   = 1'b0,
        SRC_INSTR = 1'b1
    } wdog_src_e;

    // Width of the prescaler that makes the instruction clock from clk.
    localparam int unsigned PRESCALE_W = 2;

endpackage

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Divides the block clock by 2^PRE_W and emits a one-cycle tick when the
// divider wraps. Holds while run is low; returns to zero on clr.
// Assumes clr and run are synchronous to clk.
module wdog_prescaler #(
    parameter int unsigned PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick_o
);

    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    // Advance the divider when allowed to run, restart it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Tick on the cycle the divider sits at its top value while running.
    always_comb begin
        tick_o = run && (pre_q == PRE_TOP);
    end

endmodule

// File: rtl/wdog_src_mux.sv
// Module: wdog_src_mux
// Picks the tick that drives the watchdog count and gates it with the
// global disable. Purely combinational; both tick inputs are one-cycle
// enables in the clk domain.
module wdog_src_mux
    import wdog_pkg::*;
(
    input  logic cfg_disable,
    input  logic cfg_src_sel,
    input  logic osc_tick,
    input  logic instr_tick,
    output logic tick_o
);

    wdog_src_e src;

    // Map the raw select bit onto the named source codes.
    always_comb begin
        src = wdog_src_e'(cfg_src_sel);
    end

    // Forward the selected tick unless the watchdog is switched off.
    always_comb begin
        unique case (src)
            SRC_INSTR: tick_o = instr_tick;
            default:   tick_o = osc_tick;
        endcase
        if (cfg_disable) begin
            tick_o = 1'b0;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Counts source ticks up to one of 2^RATIO_W power-of-two terminal values,
// then pulses timeout for one cycle and starts again from zero.
// Assumes cfg_ratio is static while counting; clr has priority over tick.
module wdog_counter #(
    parameter int unsigned BASE_LOG2 = 13,
    parameter int unsigned RATIO_W   = 2,
    parameter int unsigned CNT_W     = BASE_LOG2 + (1 << RATIO_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic [RATIO_W-1:0] cfg_ratio,
    output logic [CNT_W-1:0]   count_o,
    output logic               timeout_o
);

    localparam int unsigned STEPS = 1 << RATIO_W;

    logic [CNT_W-1:0] cnt_q;
    logic             to_q;
    logic [STEPS-1:0] tc_hit;
    logic             at_end;

    // One terminal compare per selectable ratio.
    for (genvar g = 0; g < STEPS; g++) begin : g_term
        localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
        always_comb begin
            tc_hit[g] = (cnt_q == LAST);
        end
    end

    // Select the compare that belongs to the configured ratio.
    always_comb begin
        at_end = tc_hit[cfg_ratio];
    end

    // Count ticks, wrap at the terminal value and flag the expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else if (tick && at_end) begin
            cnt_q <= '0;
            to_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            to_q  <= 1'b0;
        end else begin
            to_q  <= 1'b0;
        end
    end

    assign count_o   = cnt_q;
    assign timeout_o = to_q;

endmodule

// File: rtl/wdog_top.sv
// Module: wdog_top
// Watchdog timer: a prescaler makes the instruction clock, a mux picks the
// counting source, and a counter expires after 2^(BASE_LOG2+cfg_ratio)
// ticks. Configuration inputs are static; all inputs are synchronous to clk.
module wdog_top #(
    parameter int unsigned BASE_LOG2 = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_disable,
    input  logic       cfg_src_sel,
    input  logic [1:0] cfg_ratio,
    input  logic       osc_tick,
    input  logic       pwr_down,
    input  logic       sw_clear,
    output logic       wdt_timeout
);

    localparam int unsigned RATIO_W = 2;
    localparam int unsigned CNT_W   = BASE_LOG2 + (1 << RATIO_W) - 1;

    logic             clr_all;
    logic             instr_tick;
    logic             cnt_tick;
    logic [CNT_W-1:0] count_w;

    // Software clear and the disable option both restart the timer.
    always_comb begin
        clr_all = sw_clear || cfg_disable;
    end

    wdog_prescaler #(
        .PRE_W (wdog_pkg::PRESCALE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!pwr_down),
        .clr    (clr_all),
        .tick_o (instr_tick)
    );

    wdog_src_mux u_mux (
        .cfg_disable (cfg_disable),
        .cfg_src_sel (cfg_src_sel),
        .osc_tick    (osc_tick),
        .instr_tick  (instr_tick),
        .tick_o      (cnt_tick)
    );

    wdog_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .RATIO_W   (RATIO_W),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_all),
        .tick      (cnt_tick),
        .cfg_ratio (cfg_ratio),
        .count_o   (count_w),
        .timeout_o (wdt_timeout)
    );

endmodule

// File: rtl/wdog_checker.sv
// Module: wdog_checker
// Temporal properties of the watchdog, bound into wdog_top.
module wdog_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_disable,
    input logic             cfg_src_sel,
    input logic             pwr_down,
    input logic             sw_clear,
    input logic [CNT_W-1:0] count,
    input logic             wdt_timeout
);

    // R4: expiry is a single-cycle pulse.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R4: the count has restarted while the pulse is visible.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |-> (count == '0));

    // R2: the count only steps by one or returns to zero.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == '0 || count == $past(count) + 1'b1));

    // R5: a clear leaves a zero count and no expiry.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (count == '0 && !wdt_timeout));

    // R6: disabled means silent and held at zero.
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_disable |=> (!wdt_timeout && count == '0));

    // R8: instruction source freezes during power-down.
    a_r8_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src_sel && pwr_down && !sw_clear && !cfg_disable) |=> ($stable(count) && !wdt_timeout));

endmodule

bind wdog_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_disable (cfg_disable),
    .cfg_src_sel (cfg_src_sel),
    .pwr_down    (pwr_down),
    .sw_clear    (sw_clear),
    .count       (count_w),
    .wdt_timeout (wdt_timeout)
);

// File: tb/tb_wdog_top.sv
// Directed bench for wdog_top built with BASE_LOG2 = 4 (periods 16..128).
module tb_wdog_top;

    localparam int unsigned B = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_disable = 1'b0;
    logic       cfg_src_sel = 1'b0;
    logic [1:0] cfg_ratio = 2'd0;
    logic       osc_tick = 1'b0;
    logic       pwr_down = 1'b0;
    logic       sw_clear = 1'b0;
    logic       wdt_timeout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    wdog_top #(.BASE_LOG2(B)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_disable (cfg_disable),
        .cfg_src_sel (cfg_src_sel),
        .cfg_ratio   (cfg_ratio),
        .osc_tick    (osc_tick),
        .pwr_down    (pwr_down),
        .sw_clear    (sw_clear),
        .wdt_timeout (wdt_timeout)
    );

    always #2 clk = ~clk;

    function automatic int period(input int r);
        return 1 << (B + r);
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Pulse n oscillator ticks on consecutive cycles; count expiries seen.
    task automatic osc_ticks(input int n, output int hits, output logic last);
        hits = 0;
        last = 1'b0;
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1;
            @(negedge clk);
            last = wdt_timeout;
            if (wdt_timeout) hits++;
        end
        osc_tick = 1'b0;
    endtask

    // Let n clock edges pass with inputs unchanged; count expiries seen.
    task automatic run_cycles(input int n, output int hits, output logic last);
        hits = 0;
        last = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            last = wdt_timeout;
            if (wdt_timeout) hits++;
        end
    endtask

    task automatic do_clear();
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
    endtask

    task automatic t_reset();
        int h; logic l;
        rst_n = 1'b0;
        osc_tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 timeout low in reset", wdt_timeout, 0);
        osc_tick = 1'b0;
        rst_n = 1'b1;
        osc_ticks(period(0) - 1, h, l);
        check("R1 no early expiry after reset", h, 0);
        osc_ticks(1, h, l);
        check("R1 full period after reset", l, 1);
        run_cycles(1, h, l);
    endtask

    task automatic t_osc_ratios();
        int h; logic l;
        cfg_src_sel = 1'b0;
        for (int r = 0; r < 4; r++) begin
            cfg_ratio = 2'(r);
            do_clear();
            osc_ticks(period(r) - 1, h, l);
            check("R2 no expiry before N ticks", h, 0);
            osc_ticks(1, h, l);
            check("R2 expiry on N-th tick", l, 1);
            run_cycles(1, h, l);
        end
        cfg_ratio = 2'd0;
    endtask

    task automatic t_pulse_restart();
        int h; logic l;
        cfg_src_sel = 1'b0;
        cfg_ratio = 2'd1;
        do_clear();
        osc_ticks(period(1), h, l);
        check("R4 first expiry", l, 1);
        run_cycles(1, h, l);
        check("R4 pulse lasts one cycle", l, 0);
        osc_ticks(period(1) - 1, h, l);
        check("R4 restart from zero, no early expiry", h, 0);
        osc_ticks(1, h, l);
        check("R4 second expiry after N more ticks", l, 1);
        run_cycles(1, h, l);
        cfg_ratio = 2'd0;
    endtask

    task automatic t_instr();
        int h; logic l;
        int n;
        cfg_src_sel = 1'b1;
        cfg_ratio = 2'd2;
        n = period(2);
        osc_tick = 1'b1;               // R9: must be ignored
        do_clear();
        osc_tick = 1'b1;
        run_cycles(4 * n - 1, h, l);
        check("R3 no expiry before 4N edges", h, 0);
        check("R9 osc ticks ignored on instruction source", h, 0);
        run_cycles(1, h, l);
        check("R3 expiry on 4N-th edge", l, 1);
        run_cycles(1, h, l);
        check("R3 pulse ends", l, 0);
        osc_tick = 1'b0;
        cfg_ratio = 2'd0;
    endtask

    task automatic t_clear();
        int h; logic l;
        cfg_src_sel = 1'b0;
        do_clear();
        osc_ticks(10, h, l);
        do_clear();
        osc_ticks(period(0) - 1, h, l);
        check("R5 clear mid-count restarts period", h, 0);
        osc_ticks(1, h, l);
        check("R5 expiry N ticks after clear", l, 1);
        run_cycles(1, h, l);
        do_clear();
        osc_ticks(period(0) - 1, h, l);
        osc_tick = 1'b1;
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
        osc_tick = 1'b0;
        check("R5 clear wins over coincident terminal tick", wdt_timeout, 0);
        osc_ticks(period(0) - 1, h, l);
        check("R5 count zeroed by coincident clear", h, 0);
        osc_ticks(1, h, l);
        check("R5 expiry after full period", l, 1);
        run_cycles(1, h, l);
    endtask

    task automatic t_disable();
        int h; logic l;
        int tot;
        cfg_src_sel = 1'b0;
        cfg_disable = 1'b1;
        osc_ticks(2 * period(3), h, l);
        tot = h;
        do_clear();
        if (wdt_timeout) tot++;
        cfg_src_sel = 1'b1;
        run_cycles(8 * period(3), h, l);
        tot += h;
        check("R6 no expiry while disabled", tot, 0);
        cfg_src_sel = 1'b0;
        cfg_disable = 1'b0;
        do_clear();
        osc_ticks(10, h, l);
        cfg_disable = 1'b1;
        @(negedge clk);
        cfg_disable = 1'b0;
        osc_ticks(period(0) - 1, h, l);
        check("R6 count held at zero while disabled", h, 0);
        osc_ticks(1, h, l);
        check("R6 full period after re-enable", l, 1);
        run_cycles(1, h, l);
    endtask

    task automatic t_powerdown();
        int h; logic l;
        int n;
        cfg_src_sel = 1'b0;
        do_clear();
        pwr_down = 1'b1;
        osc_ticks(period(0), h, l);
        check("R7 oscillator source expires in power-down", l, 1);
        run_cycles(1, h, l);
        pwr_down = 1'b0;
        cfg_src_sel = 1'b1;
        n = period(0);
        do_clear();
        run_cycles(4 * n - 4, h, l);
        check("R8 no expiry before power-down", h, 0);
        pwr_down = 1'b1;
        run_cycles(50, h, l);
        check("R8 instruction source holds in power-down", h, 0);
        pwr_down = 1'b0;
        run_cycles(3, h, l);
        check("R8 no expiry in first 3 edges after wake", h, 0);
        run_cycles(1, h, l);
        check("R8 resumes and expires on 4th edge", l, 1);
        run_cycles(1, h, l);
    endtask

    task automatic t_osc_idle();
        int h; logic l;
        cfg_src_sel = 1'b0;
        do_clear();
        run_cycles(8 * period(0), h, l);
        check("R9 oscillator source ignores plain clock cycles", h, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_osc_ratios();
        t_pulse_restart();
        t_instr();
        t_clear();
        t_disable();
        t_powerdown();
        t_osc_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule